// File: doc/BRIEF.md
# Source-Routed Crossbar Packet Switch

This block is a multi-port packet switch for an on-chip network. It connects processor network interfaces to each other and to link ports that leave the chip. Every port has a one-way input stream with valid/ready handshaking and a one-way output stream. Each input keeps a separate buffer for each of two virtual channels. A packet starts with a header flit. The low bits of the header hold a source route: a list of 4-bit entries, each naming an output port. The header also holds a length field. The switch reads the first route entry and connects the packet through a full crossbar to the named output. On the way out it shifts that entry out of the header, so the next switch finds its own entry at the bottom. Payload flits pass through untouched until the flit that carries the tail flag.

Flow control is virtual cut-through. A packet may be granted an output before its tail has arrived, but only when the downstream buffer for the outgoing virtual channel has room for the whole packet. The switch keeps a credit counter for every output and virtual channel. It reserves the packet's full length at grant time. Downstream logic returns the credits one flit at a time. Each output picks among competing input/channel pairs in round-robin order and keeps its grant until the tail has left. Traffic that leaves through the off-board port is moved to the escape channel, which breaks cyclic buffer dependencies between boards. A header whose first entry names no port is discarded up to its tail, and a drop counter is incremented.

Top module: `xsw_switch`

## Requirements
- R1: After reset, every in_ready bit is 1, every out_valid bit is 0, and drop_count is 0.
- R2: Header layout: bits [19:0] hold five 4-bit route entries, with the current entry in bits [3:0]. Bits [24:20] hold the packet length in flits, counting the header, from 1 to DOWN_DEPTH. Bits [31:28] are user bits. Entry values 0 to N_PORTS-1 select that output port. The value 4'hF selects LOCAL_PORT (port 0).
- R3: The forwarded header carries its route field shifted right by one entry, with 4'hF filled in at bits [19:16]. All other header bits and all payload flits leave unchanged, in order, with the tail flag on the last flit.
- R4: A packet whose first entry is between N_PORTS and 14 is consumed up to and including its tail flit. Nothing from it appears on any output, and drop_count rises by one. The next packet on the same input and channel is forwarded normally.
- R5: A header is not forwarded until the credit count for its output and outgoing channel is at least the packet length. The full length is reserved at grant, and each out_credit pulse returns one credit (index port*2+vc, DOWN_DEPTH credits per channel after reset).
- R6: Once an output is granted, it carries only that packet's flits, back to back, until the tail flit. Packets never interleave on an output.
- R7: Competing input/channel pairs (index port*2+vc) are served in round-robin order, starting after the last winner.
- R8: Packets leaving through OFFBOARD_PORT (port 3) carry out_vc = 1. Packets leaving through any other port keep the channel they arrived on.
- R9: The two virtual channels of an input are independent. A packet waiting for credits on channel 0 does not hold back a channel-1 packet from the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_PORTS | Input flit valid, per port |
| in_vc | input | N_PORTS | Virtual channel of the input flit, per port |
| in_data | input | N_PORTS*32 | Input flit data, per port |
| in_tail | input | N_PORTS | Input flit is the last of its packet |
| in_ready | output | N_PORTS*2 | Buffer space available, per port and channel (index port*2+vc) |
| out_valid | output | N_PORTS | Output flit valid, per port |
| out_vc | output | N_PORTS | Virtual channel of the output flit |
| out_data | output | N_PORTS*32 | Output flit data |
| out_tail | output | N_PORTS | Output flit is the last of its packet |
| out_credit | input | N_PORTS*2 | One-credit return pulse, per port and channel |
| drop_count | output | 8 | Number of packets discarded for a bad route entry |

## Verification
Most internal faults show up at the outputs within a few cycles of the affected packet. A wrong owner or a grant held too long puts flits from another packet into an output stream. A failed shift corrupts the next route entry in the first forwarded header. A credit count that drifts either lets a header out while the downstream buffer is short, or holds it back once credits have been returned. A stuck drop state swallows the next good packet on that channel, so it never arrives. The bench tracks every expected flit per packet and compares each output on every clock, so any of these faults is reported at the first flit that differs.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  localparam int DW      = 32;
  localparam int ENT_W   = 4;
  localparam int N_ENT   = 5;
  localparam int RT_W    = ENT_W * N_ENT;
  localparam int LEN_LSB = RT_W;
  localparam int LEN_W   = 5;
  localparam int NVC     = 2;
  localparam int VC_W    = 1;
  localparam int ESC_VC  = 1;
  localparam logic [ENT_W-1:0] LOCAL_CODE = '1;

  // advance the route: drop the leading entry, pad the far end with the local code
  function automatic logic [DW-1:0] strip_route(input logic [DW-1:0] h);
    logic [DW-1:0] r;
    r = h;
    r[RT_W-1:0] = {LOCAL_CODE, h[RT_W-1:ENT_W]};
    return r;
  endfunction
endpackage

// File: rtl/xsw_vc_fifo.sv
module xsw_vc_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_en) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (rd_en) rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    if (wr_en && !rd_en) cnt_d = cnt_q + 1'b1;
    else if (!wr_en && rd_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/xsw_rr_arb.sv
module xsw_rr_arb #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    int idx;
    any     = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      idx = (int'(ptr_q) + i) % N;
      if (!any && req[idx]) begin
        any     = 1'b1;
        gnt_idx = IW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && any) ptr_d = (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/xsw_credit.sv
module xsw_credit #(
  parameter int MAX   = 8,
  parameter int LEN_W = 5,
  parameter int CW    = $clog2(MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LEN_W-1:0] take_len,
  input  logic             give,
  output logic [CW-1:0]    avail
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (take) cnt_d = cnt_d - CW'(take_len);
    if (give) cnt_d = cnt_d + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(MAX);
    else        cnt_q <= cnt_d;
  end

  assign avail = cnt_q;
endmodule

// File: rtl/xsw_switch.sv
module xsw_switch
  import xsw_pkg::*;
#(
  parameter int N_PORTS       = 4,
  parameter int FIFO_DEPTH    = 8,
  parameter int DOWN_DEPTH    = 8,
  parameter int LOCAL_PORT    = 0,
  parameter int OFFBOARD_PORT = 3,
  parameter int CNT_W         = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_PORTS-1:0]            in_valid,
  input  logic [N_PORTS-1:0]            in_vc,
  input  logic [N_PORTS-1:0][DW-1:0]    in_data,
  input  logic [N_PORTS-1:0]            in_tail,
  output logic [N_PORTS*NVC-1:0]        in_ready,
  output logic [N_PORTS-1:0]            out_valid,
  output logic [N_PORTS-1:0]            out_vc,
  output logic [N_PORTS-1:0][DW-1:0]    out_data,
  output logic [N_PORTS-1:0]            out_tail,
  input  logic [N_PORTS*NVC-1:0]        out_credit,
  output logic [CNT_W-1:0]              drop_count
);
  localparam int NQ = N_PORTS * NVC;
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int CW = $clog2(DOWN_DEPTH + 1);
  localparam int FW = DW + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_l  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_l  <= rst_s1;
    end
  end

  // per input/channel queues
  logic [FW-1:0]    q_dout  [NQ];
  logic [NQ-1:0]    q_empty, q_full, q_pop, q_push;
  logic [ENT_W-1:0] hd_code [NQ];
  logic [LEN_W-1:0] hd_len  [NQ];
  logic [PW-1:0]    hd_port [NQ];
  logic [NQ-1:0]    hd_ok, owned, pop_own, drop_start, drop_pop, drop_st;

  // per output state, visible across generate scopes
  logic              busy    [N_PORTS];
  logic [QW-1:0]     owner   [N_PORTS];
  logic [NQ-1:0]     req     [N_PORTS];
  logic [CW-1:0]     avail   [N_PORTS][NVC];
  logic [N_PORTS-1:0]          busy_vec;
  logic [N_PORTS*NVC*CW-1:0]   avail_flat;

  for (genvar q = 0; q < NQ; q++) begin : g_in
    localparam int P = q / NVC;
    localparam int V = q % NVC;
    logic ds_q, ds_d;

    assign q_push[q]   = in_valid[P] && (in_vc[P] == VC_W'(V)) && !q_full[q];
    assign in_ready[q] = !q_full[q];

    xsw_vc_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_l),
      .wr_en(q_push[q]), .wr_data({in_tail[P], in_data[P]}),
      .rd_en(q_pop[q]), .rd_data(q_dout[q]),
      .empty(q_empty[q]), .full(q_full[q])
    );

    assign hd_code[q] = q_dout[q][ENT_W-1:0];
    assign hd_len[q]  = q_dout[q][LEN_LSB +: LEN_W];
    assign hd_ok[q]   = (hd_code[q] == LOCAL_CODE) || (int'(hd_code[q]) < N_PORTS);
    assign hd_port[q] = (hd_code[q] == LOCAL_CODE) ? PW'(LOCAL_PORT) : PW'(hd_code[q]);

    assign drop_start[q] = !q_empty[q] && !owned[q] && !ds_q && !hd_ok[q];
    assign drop_pop[q]   = drop_start[q] || (ds_q && !q_empty[q]);
    assign q_pop[q]      = drop_pop[q] || pop_own[q];
    assign drop_st[q]    = ds_q;

    always_comb begin
      ds_d = ds_q;
      if (drop_start[q])                          ds_d = !q_dout[q][DW];
      else if (ds_q && !q_empty[q] && q_dout[q][DW]) ds_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l) ds_q <= 1'b0;
      else        ds_q <= ds_d;
    end
  end

  // ownership and the pops that granted outputs make
  always_comb begin
    owned   = '0;
    pop_own = '0;
    for (int o = 0; o < N_PORTS; o++) begin
      for (int q = 0; q < NQ; q++) begin
        if (busy[o] && owner[o] == QW'(q)) begin
          owned[q] = 1'b1;
          if (!q_empty[q]) pop_own[q] = 1'b1;
        end
      end
    end
  end

  // requests: head header, free, decodable, this port, whole packet fits downstream
  always_comb begin
    int vm;
    for (int o = 0; o < N_PORTS; o++) begin
      req[o] = '0;
      for (int q = 0; q < NQ; q++) begin
        vm = (o == OFFBOARD_PORT) ? ESC_VC : (q % NVC);
        req[o][q] = !q_empty[q] && !owned[q] && !drop_st[q] && hd_ok[q]
                    && (int'(hd_port[q]) == o)
                    && (int'(avail[o][vm]) >= int'(hd_len[q]));
      end
    end
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    logic [QW-1:0]     gq;
    logic              g_any, grant, pop_o;
    logic [VC_W-1:0]   gvc;
    logic [FW-1:0]     cur;
    logic              busy_q, busy_d, first_q, first_d;
    logic [QW-1:0]     own_q, own_d;
    logic [VC_W-1:0]   ovc_q, ovc_d;
    logic              ov_q, ov_d, ot_q, ot_d;
    logic [VC_W-1:0]   oc_q, oc_d;
    logic [DW-1:0]     od_q, od_d;

    xsw_rr_arb #(.N(NQ), .IW(QW)) u_arb (
      .clk(clk), .rst_n(rst_l), .req(req[o]), .adv(!busy_q),
      .gnt_idx(gq), .any(g_any)
    );

    assign grant = !busy_q && g_any;
    assign gvc   = (o == OFFBOARD_PORT) ? VC_W'(ESC_VC) : VC_W'(int'(gq) % NVC);
    assign cur   = q_dout[own_q];
    assign pop_o = busy_q && !q_empty[own_q];

    for (genvar v = 0; v < NVC; v++) begin : g_cr
      xsw_credit #(.MAX(DOWN_DEPTH), .LEN_W(LEN_W), .CW(CW)) u_cr (
        .clk(clk), .rst_n(rst_l),
        .take(grant && gvc == VC_W'(v)), .take_len(hd_len[gq]),
        .give(out_credit[o*NVC+v]), .avail(avail[o][v])
      );
      assign avail_flat[(o*NVC+v)*CW +: CW] = avail[o][v];
    end

    always_comb begin
      busy_d  = busy_q;
      own_d   = own_q;
      first_d = first_q;
      ovc_d   = ovc_q;
      if (grant) begin
        busy_d  = 1'b1;
        own_d   = gq;
        first_d = 1'b1;
        ovc_d   = gvc;
      end else if (pop_o) begin
        first_d = 1'b0;
        if (cur[DW]) busy_d = 1'b0;
      end
      ov_d = pop_o;
      ot_d = pop_o && cur[DW];
      oc_d = ovc_q;
      od_d = first_q ? strip_route(cur[DW-1:0]) : cur[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l) begin
        busy_q  <= 1'b0;
        own_q   <= '0;
        first_q <= 1'b0;
        ovc_q   <= '0;
        ov_q    <= 1'b0;
        ot_q    <= 1'b0;
        oc_q    <= '0;
        od_q    <= '0;
      end else begin
        busy_q  <= busy_d;
        own_q   <= own_d;
        first_q <= first_d;
        ovc_q   <= ovc_d;
        ov_q    <= ov_d;
        if (pop_o) begin
          ot_q <= ot_d;
          oc_q <= oc_d;
          od_q <= od_d;
        end
      end
    end

    assign busy[o]      = busy_q;
    assign owner[o]     = own_q;
    assign busy_vec[o]  = busy_q;
    assign out_valid[o] = ov_q;
    assign out_tail[o]  = ot_q;
    assign out_vc[o]    = oc_q;
    assign out_data[o]  = od_q;
  end

  // drop counter
  logic [CNT_W-1:0] drop_q, drop_d;
  always_comb drop_d = drop_q + CNT_W'($countones(drop_start));
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) drop_q <= '0;
    else        drop_q <= drop_d;
  end
  assign drop_count = drop_q;
endmodule

// File: rtl/xsw_switch_chk.sv
module xsw_switch_chk #(
  parameter int N_PORTS       = 4,
  parameter int NVC           = 2,
  parameter int CW            = 4,
  parameter int DOWN_DEPTH    = 8,
  parameter int OFFBOARD_PORT = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_PORTS-1:0]          out_valid,
  input logic [N_PORTS-1:0]          out_tail,
  input logic [N_PORTS-1:0]          out_vc,
  input logic [N_PORTS-1:0]          busy_vec,
  input logic [N_PORTS*NVC*CW-1:0]   avail_flat
);
  AST_ESCAPE_VC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[OFFBOARD_PORT] |-> out_vc[OFFBOARD_PORT]); // R8

  for (genvar o = 0; o < N_PORTS; o++) begin : g_o
    AST_TAIL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && out_tail[o]) |-> !busy_vec[o]); // R6
    AST_MID_PACKET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_tail[o]) |-> busy_vec[o]); // R6
    for (genvar v = 0; v < NVC; v++) begin : g_v
      AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(avail_flat[(o*NVC+v)*CW +: CW]) <= DOWN_DEPTH); // R5
    end
  end
endmodule

bind xsw_switch xsw_switch_chk #(
  .N_PORTS(N_PORTS), .NVC(xsw_pkg::NVC), .CW(CW),
  .DOWN_DEPTH(DOWN_DEPTH), .OFFBOARD_PORT(OFFBOARD_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_l), .out_valid(out_valid), .out_tail(out_tail),
  .out_vc(out_vc), .busy_vec(busy_vec), .avail_flat(avail_flat)
);

// File: tb/xsw_switch_test.sv
module xsw_switch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]        in_valid = '0;
  logic [3:0]        in_vc = '0;
  logic [3:0][31:0]  in_data = '0;
  logic [3:0]        in_tail = '0;
  logic [7:0]        in_ready;
  logic [3:0]        out_valid, out_vc, out_tail;
  logic [3:0][31:0]  out_data;
  logic [7:0]        out_credit = '0;
  logic [7:0]        drop_count;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  xsw_switch uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_data(in_data), .in_tail(in_tail), .in_ready(in_ready),
    .out_valid(out_valid), .out_vc(out_vc), .out_data(out_data),
    .out_tail(out_tail), .out_credit(out_credit), .drop_count(drop_count)
  );

  // reference model: expected flits per packet tag, {vc, tail, data}
  logic [33:0] expq [16][$];
  int    exp_port [16];
  string exp_req  [16];
  bit    hdr_seen [16];
  bit    in_pkt   [4];
  int    cur_tag  [4];
  int    order0[$];
  bit    hold [8];
  int    owed [8];
  bit    monitor_on = 1'b0;

  initial for (int t = 0; t < 16; t++) exp_port[t] = -1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int p, input int vc, input logic [19:0] route,
                      input int len, input int tag, input string req,
                      input int outp);
    logic [31:0] hdr;
    logic [31:0] w;
    hdr = {tag[3:0], 3'b000, len[4:0], route};
    if (outp >= 0) begin
      exp_port[tag] = outp;
      exp_req[tag]  = req;
      for (int i = 0; i < len; i++) begin
        w = (i == 0) ? {hdr[31:20], 4'hF, route[19:4]} : {tag[3:0], 28'(i * 17 + p)};
        expq[tag].push_back({((outp == 3) ? 1'b1 : 1'(vc)), (i == len - 1), w});
      end
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid[p] = 1'b1;
      in_vc[p]    = 1'(vc);
      in_data[p]  = (i == 0) ? hdr : {tag[3:0], 28'(i * 17 + p)};
      in_tail[p]  = (i == len - 1);
      #1;
      while (!in_ready[p*2+vc]) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
    in_tail[p]  = 1'b0;
  endtask

  // downstream side: credit return and flit comparison on every clock
  always @(negedge clk) begin
    if (monitor_on) begin
      logic [7:0] cr;
      int idx, tg;
      cr = '0;
      for (int o = 0; o < 4; o++) begin
        if (out_valid[o]) begin
          idx = o * 2 + int'(out_vc[o]);
          if (hold[idx]) owed[idx]++;
          else cr[idx] = 1'b1;
          if (!in_pkt[o]) begin
            tg = int'(out_data[o][31:28]);
            if (exp_port[tg] != o || expq[tg].size() == 0) begin
              check(1'b0, "R2", "unexpected packet at port", o, exp_port[tg]);
              continue;
            end
            in_pkt[o] = 1'b1;
            cur_tag[o] = tg;
            hdr_seen[tg] = 1'b1;
            if (o == 0) order0.push_back(tg);
          end
          tg = cur_tag[o];
          if (expq[tg].size() == 0) begin
            check(1'b0, exp_req[tg], "extra flit", out_data[o], 0);
            in_pkt[o] = 1'b0;
          end else begin
            check({out_vc[o], out_tail[o], out_data[o]} == expq[tg][0], exp_req[tg],
                  "flit {vc,tail,data}", {out_vc[o], out_tail[o], out_data[o]}, expq[tg][0]);
            void'(expq[tg].pop_front());
            if (out_tail[o]) in_pkt[o] = 1'b0;
          end
        end
      end
      for (int k = 0; k < 8; k++)
        if (!hold[k] && owed[k] > 0 && !cr[k]) begin
          cr[k] = 1'b1;
          owed[k]--;
        end
      out_credit = cr;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(in_ready == 8'hFF, "R1", "in_ready after reset", in_ready, 8'hFF);
    check(out_valid == 4'h0, "R1", "out_valid after reset", out_valid, 0);
    check(drop_count == 8'd0, "R1", "drop_count after reset", drop_count, 0);
    monitor_on = 1'b1;

    // R2 local code, header-only packet
    send(2, 0, 20'hFFFFF, 1, 10, "R2", 0);
    // R3 multi-hop route advance, arriving on channel 1
    send(0, 1, 20'hF0312, 4, 12, "R3", 2);
    // R8 off-board port moves to escape channel
    send(1, 0, 20'hFFF13, 3, 11, "R8", 3);
    // R6 two inputs to two outputs at once
    fork
      send(0, 0, 20'hFFFF1, 3, 13, "R6", 1);
      send(3, 1, 20'hFFFF2, 3, 14, "R6", 2);
    join
    repeat (12) @(negedge clk);

    // R7 round-robin between port 1 and port 2 into port 0
    order0.delete();
    fork
      begin send(1, 0, 20'hFFFF0, 3, 1, "R6", 0); send(1, 0, 20'hFFFF0, 3, 3, "R6", 0); end
      begin send(2, 0, 20'hFFFF0, 3, 2, "R6", 0); send(2, 0, 20'hFFFF0, 3, 4, "R6", 0); end
    join
    repeat (20) @(negedge clk);
    check(order0.size() == 4, "R7", "packets served at port 0", order0.size(), 4);
    for (int i = 0; i < 4 && i < order0.size(); i++)
      check(order0[i] == i + 1, "R7", "round-robin service order", order0[i], i + 1);

    // R5 credit gating with R9 channel independence
    hold[4] = 1'b1;
    send(1, 0, 20'hFFFF2, 6, 5, "R5", 2);
    send(1, 0, 20'hFFFF2, 6, 6, "R5", 2);
    send(1, 1, 20'hFFFF2, 4, 7, "R9", 2);
    repeat (30) @(negedge clk);
    check(hdr_seen[5] && expq[5].size() == 0, "R5", "first packet delivered", expq[5].size(), 0);
    check(!hdr_seen[6], "R5", "packet held without credits", hdr_seen[6], 0);
    check(expq[7].size() == 0, "R9", "other channel not blocked", expq[7].size(), 0);
    hold[4] = 1'b0;
    repeat (30) @(negedge clk);
    check(expq[6].size() == 0, "R5", "held packet sent after credits", expq[6].size(), 0);

    // R4 bad route entry dropped, next packet unaffected
    send(3, 0, 20'hFFFFE, 3, 8, "R4", -1);
    send(3, 0, 20'hFFFF1, 2, 9, "R4", 1);
    repeat (20) @(negedge clk);
    check(drop_count == 8'd1, "R4", "drop_count after bad entry", drop_count, 1);
    check(expq[9].size() == 0 && hdr_seen[9], "R4", "packet after drop delivered", expq[9].size(), 0);
    check(!hdr_seen[8], "R4", "dropped packet absent", hdr_seen[8], 0);

    for (int t = 1; t < 15; t++)
      if (exp_port[t] >= 0)
        check(expq[t].size() == 0, exp_req[t], "all flits delivered", expq[t].size(), 0);
    finish_run();
  end
endmodule